// File: doc/BRIEF.md
# Core Standby Wait Controller

This block puts one processor core into an interrupt-kind or event-kind wait. The decode stage raises `wait_req` for one cycle when it sees a wait instruction and gives its kind on `wait_kind`. The controller first waits for the core's memory traffic to drain. Then it drops the core clock enable and raises the standby flag for that kind. It leaves the wait when a wake condition that suits the kind arrives.

While the core waits, three kinds of service traffic can turn the clock back on for a short time without ending the wait:
- a snoop aimed at the L1 data cache,
- a cache, TLB or branch-predictor maintenance request,
- a debug or trace register access.

The standby flag stays high while that traffic is served. The clock gating cell itself lies outside the block and is modelled here by `core_clk_en`.

The controller has three states:
- **ST_RUN**: the core runs.
- **ST_DRAIN**: the wait has been accepted and the controller is waiting for memory traffic to finish.
- **ST_SLEEP**: the core is idle and its standby flag is high.

It has these transitions:
- **T_ACCEPT**: ST_RUN to ST_DRAIN, on `wait_req` while traffic is outstanding.
- **T_DIRECT**: ST_RUN to ST_SLEEP, on `wait_req` when nothing is outstanding.
- **T_SETTLE**: ST_DRAIN to ST_SLEEP, once both counts read zero.
- **T_WAKE**: ST_SLEEP to ST_RUN, on a matching wake or a remembered wake.
- **T_ABORT**: any state to ST_RUN, on `soft_rst`.

A wake that arrives while the wait is being accepted (T_ACCEPT or T_DIRECT) or during ST_DRAIN is kept in a pending flag, so it is not lost.

Top module: `core_standby_ctrl`

## Requirements
- R1: The controller does not enter ST_SLEEP while `pend_loads` (loads, maintenance operations and exclusive stores still waiting for a response) is nonzero. It enters at the edge after the cycle in which both counts read zero.
- R2: The controller does not enter ST_SLEEP while `pend_stores` (stores that have neither updated the cache nor been issued onward) is nonzero.
- R3: In ST_SLEEP, `standby_int` is high when the wait was accepted with `wait_kind`=0 and `standby_evt` is high when it was accepted with `wait_kind`=1. The two flags are never high together, and `core_clk_en` is low unless a service window is open. Outside ST_SLEEP both flags are low and `core_clk_en` is high.
- R4: In ST_SLEEP, `core_clk_en` is high in every cycle in which `snoop_req`, `maint_req` or `dbgreg_req` is high, and in the one cycle that follows. The standby flag stays high throughout.
- R5: An interrupt-kind wait ends when `irq_n` or `fiq_n` is low (active low; the standby flag falls after the third rising edge counted from the first edge that samples the input low) or when `dbg_wake` is high (the flag falls after the next edge). `event_in` does not end an interrupt-kind wait.
- R6: An event-kind wait ends one edge after `event_in` is high. It also ends on any wake condition that ends an interrupt-kind wait.
- R7: `soft_rst` returns the controller to ST_RUN at the next edge from any state. An active-low `rst_n` does so at once.
- R8: A wake that matches the kind and is seen in the accept cycle or during ST_DRAIN is kept. The controller then spends exactly one cycle in ST_SLEEP and returns to ST_RUN.
- R9: `wait_req` has no effect outside ST_RUN. The active standby flag and its kind are unchanged.
- R10: In reset and right after it, `core_clk_en`=1, `standby_int`=0 and `standby_evt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset; ends any wait |
| wait_req | input | 1 | One-cycle pulse from decode marking a wait instruction |
| wait_kind | input | 1 | 0 = interrupt-kind wait, 1 = event-kind wait |
| pend_loads | input | CNT_W | Count of loads, maintenance operations and exclusive stores awaiting response |
| pend_stores | input | CNT_W | Count of stores not yet written to cache or issued onward |
| irq_n | input | 1 | Asynchronous interrupt, active low |
| fiq_n | input | 1 | Asynchronous fast interrupt, active low |
| dbg_wake | input | 1 | Debug wake event, synchronous |
| event_in | input | 1 | External event input, synchronous |
| snoop_req | input | 1 | L1 data-cache snoop request valid |
| maint_req | input | 1 | Cache/TLB/branch-predictor maintenance request valid |
| dbgreg_req | input | 1 | Debug/trace register access valid |
| core_clk_en | output | 1 | Enable for the core clock gate |
| standby_int | output | 1 | Core idle in an interrupt-kind wait |
| standby_evt | output | 1 | Core idle in an event-kind wait |

## Verification
Two things can happen in the same cycle: a service request that opens the clock window, and a wake that ends the wait. The bench raises `snoop_req` and `event_in` together while an event-kind wait sleeps. In that cycle it expects the clock enable and `standby_evt` to be high together, and in the next cycle it expects ST_RUN with no standby flag. A second overlap places a wake in the very cycle the wait is accepted. The bench then checks that the wait still goes through exactly one cycle of standby before it returns to running.

// File: rtl/csw_pkg.sv
package csw_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_SLEEP = 2'd2
    } csw_state_e;

    typedef enum logic {
        WK_INT = 1'b0,
        WK_EVT = 1'b1
    } csw_kind_e;

endpackage

// File: rtl/csw_sync.sv
// Two-flop synchronizer; flops reset to RST_VAL (inactive level).
module csw_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/csw_svc_win.sv
// Service clock window: open while any request is valid, plus one tail cycle.
module csw_svc_win #(
    parameter int N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] svc_vld,
    output logic             win_open
);
    logic any_vld;
    logic tail_q;

    assign any_vld = |svc_vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tail_q <= 1'b0;
        else        tail_q <= any_vld;
    end

    assign win_open = any_vld | tail_q;
endmodule

// File: rtl/csw_fsm.sv
module csw_fsm
    import csw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic wait_req,
    input  logic wait_kind,
    input  logic drained,
    input  logic wake_int,
    input  logic wake_evt,
    input  logic svc_win,
    output logic core_clk_en,
    output logic standby_int,
    output logic standby_evt
);
    csw_state_e state_q, state_d;
    csw_kind_e  kind_q,  kind_d;
    logic       pend_q,  pend_d;
    csw_kind_e  req_kind;
    logic       wake_req_kind;
    logic       wake_cur_kind;

    assign req_kind      = csw_kind_e'(wait_kind);
    assign wake_req_kind = (req_kind == WK_EVT) ? wake_evt : wake_int;
    assign wake_cur_kind = (kind_q   == WK_EVT) ? wake_evt : wake_int;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        pend_d  = pend_q;
        unique case (state_q)
            ST_RUN: begin
                pend_d = 1'b0;
                if (wait_req) begin
                    kind_d  = req_kind;
                    pend_d  = wake_req_kind;
                    state_d = drained ? ST_SLEEP : ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                pend_d = pend_q | wake_cur_kind;
                if (drained) state_d = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (wake_cur_kind || pend_q) begin
                    state_d = ST_RUN;
                    pend_d  = 1'b0;
                end
            end
            default: begin
                state_d = ST_RUN;
                pend_d  = 1'b0;
            end
        endcase
        if (soft_rst) begin
            state_d = ST_RUN;
            pend_d  = 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            kind_q  <= WK_INT;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            pend_q  <= pend_d;
        end
    end

    // Outputs
    always_comb begin
        core_clk_en = 1'b1;
        standby_int = 1'b0;
        standby_evt = 1'b0;
        unique case (state_q)
            ST_RUN, ST_DRAIN: core_clk_en = 1'b1;
            ST_SLEEP: begin
                core_clk_en = svc_win;
                standby_int = (kind_q == WK_INT);
                standby_evt = (kind_q == WK_EVT);
            end
            default: core_clk_en = 1'b1;
        endcase
    end
endmodule

// File: rtl/core_standby_ctrl.sv
module core_standby_ctrl #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             wait_req,
    input  logic             wait_kind,
    input  logic [CNT_W-1:0] pend_loads,
    input  logic [CNT_W-1:0] pend_stores,
    input  logic             irq_n,
    input  logic             fiq_n,
    input  logic             dbg_wake,
    input  logic             event_in,
    input  logic             snoop_req,
    input  logic             maint_req,
    input  logic             dbgreg_req,
    output logic             core_clk_en,
    output logic             standby_int,
    output logic             standby_evt
);
    localparam int N_IRQ = 2;
    localparam int N_SVC = 3;

    logic [N_IRQ-1:0] irq_raw_n;
    logic [N_IRQ-1:0] irq_sync_n;
    logic             drained;
    logic             wake_int;
    logic             wake_evt;
    logic             svc_win;

    assign irq_raw_n = {fiq_n, irq_n};

    csw_sync #(.W(N_IRQ), .RST_VAL({N_IRQ{1'b1}})) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (irq_raw_n),
        .dout  (irq_sync_n)
    );

    csw_svc_win #(.N_SRC(N_SVC)) u_svc (
        .clk      (clk),
        .rst_n    (rst_n),
        .svc_vld  ({dbgreg_req, maint_req, snoop_req}),
        .win_open (svc_win)
    );

    assign drained  = (pend_loads == '0) && (pend_stores == '0);
    assign wake_int = (~&irq_sync_n) | dbg_wake;
    assign wake_evt = wake_int | event_in;

    csw_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .wait_req    (wait_req),
        .wait_kind   (wait_kind),
        .drained     (drained),
        .wake_int    (wake_int),
        .wake_evt    (wake_evt),
        .svc_win     (svc_win),
        .core_clk_en (core_clk_en),
        .standby_int (standby_int),
        .standby_evt (standby_evt)
    );
endmodule

// File: rtl/csw_chk.sv
module csw_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic [CNT_W-1:0] pend_loads,
    input logic [CNT_W-1:0] pend_stores,
    input logic             event_in,
    input logic             snoop_req,
    input logic             maint_req,
    input logic             dbgreg_req,
    input logic             core_clk_en,
    input logic             standby_int,
    input logic             standby_evt
);
    logic in_stby;
    logic svc_any;
    assign in_stby = standby_int | standby_evt;
    assign svc_any = snoop_req | maint_req | dbgreg_req;

    p_no_double_standby_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({standby_int, standby_evt}));

    p_clk_off_only_standby_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !core_clk_en |-> in_stby);

    // R1 and R2: entry only after both counts were zero
    p_drain_before_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_stby && !$past(in_stby) |-> $past(pend_loads == '0 && pend_stores == '0));

    p_svc_clk_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        svc_any |-> core_clk_en);

    p_svc_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_stby && $past(in_stby) && $past(svc_any) |-> core_clk_en);

    p_evt_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        standby_evt && event_in |=> !standby_evt);

    p_soft_reset_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !in_stby);
endmodule

bind core_standby_ctrl csw_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .pend_loads  (pend_loads),
    .pend_stores (pend_stores),
    .event_in    (event_in),
    .snoop_req   (snoop_req),
    .maint_req   (maint_req),
    .dbgreg_req  (dbgreg_req),
    .core_clk_en (core_clk_en),
    .standby_int (standby_int),
    .standby_evt (standby_evt)
);

// File: tb/sim_core_standby_ctrl.sv
`timescale 1ns/1ps
module sim_core_standby_ctrl;
    localparam int CNT_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0, wait_req = 1'b0, wait_kind = 1'b0;
    logic [CNT_W-1:0] pend_loads = '0, pend_stores = '0;
    logic irq_n = 1'b1, fiq_n = 1'b1, dbg_wake = 1'b0, event_in = 1'b0;
    logic snoop_req = 1'b0, maint_req = 1'b0, dbgreg_req = 1'b0;
    logic core_clk_en, standby_int, standby_evt;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        bit    ce;
        bit    si;
        bit    se;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    core_standby_ctrl #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wait_req(wait_req), .wait_kind(wait_kind),
        .pend_loads(pend_loads), .pend_stores(pend_stores),
        .irq_n(irq_n), .fiq_n(fiq_n), .dbg_wake(dbg_wake), .event_in(event_in),
        .snoop_req(snoop_req), .maint_req(maint_req), .dbgreg_req(dbgreg_req),
        .core_clk_en(core_clk_en), .standby_int(standby_int), .standby_evt(standby_evt)
    );

    // Driver side: push the expected outputs for the current cycle
    task automatic expect_out(input bit ce, input bit si, input bit se, input string tag);
        exp_t e;
        e.ce = ce; e.si = si; e.se = se; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic nxt();
        @(posedge clk);
        #1;
    endtask

    task automatic run_cycles(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            expect_out(1'b1, 1'b0, 1'b0, tag);
            nxt();
        end
    endtask

    // Monitor: pop and compare one step after the driver
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_vec++;
                if ({core_clk_en, standby_int, standby_evt} !== {e.ce, e.si, e.se}) begin
                    n_bad++;
                    $display("FAIL %s: got ce/si/se=%b%b%b expected %b%b%b", e.tag,
                             core_clk_en, standby_int, standby_evt, e.ce, e.si, e.se);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired (all requirements): got running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #1;
        // R10: reset state
        expect_out(1, 0, 0, "R10 in reset"); nxt();
        expect_out(1, 0, 0, "R10 in reset"); nxt();
        rst_n = 1'b1;
        run_cycles(2, "R10 after reset");

        // R1/R2/R3: interrupt-kind wait with draining
        wait_req = 1; wait_kind = 0; pend_loads = 2;
        expect_out(1, 0, 0, "R1 accept cycle"); nxt();
        wait_req = 0;
        expect_out(1, 0, 0, "R1 loads outstanding"); nxt();
        pend_loads = 0; pend_stores = 1;
        expect_out(1, 0, 0, "R1 drain"); nxt();
        expect_out(1, 0, 0, "R2 stores outstanding"); nxt();
        pend_stores = 0;
        expect_out(1, 0, 0, "R2 stores outstanding"); nxt();
        expect_out(0, 1, 0, "R3 interrupt standby"); nxt();
        // R5: event input ignored in interrupt wait
        event_in = 1;
        expect_out(0, 1, 0, "R5 event seen"); nxt();
        event_in = 0;
        expect_out(0, 1, 0, "R5 event ignored"); nxt();
        // R9: new wait request ignored
        wait_req = 1; wait_kind = 1;
        expect_out(0, 1, 0, "R9 request in sleep"); nxt();
        wait_req = 0; wait_kind = 0;
        expect_out(0, 1, 0, "R9 kind unchanged"); nxt();
        // R4: service windows
        snoop_req = 1;
        expect_out(1, 1, 0, "R4 snoop"); nxt();
        expect_out(1, 1, 0, "R4 snoop held"); nxt();
        snoop_req = 0;
        expect_out(1, 1, 0, "R4 snoop tail"); nxt();
        expect_out(0, 1, 0, "R4 window closed"); nxt();
        maint_req = 1;
        expect_out(1, 1, 0, "R4 maintenance"); nxt();
        maint_req = 0;
        expect_out(1, 1, 0, "R4 maintenance tail"); nxt();
        dbgreg_req = 1;
        expect_out(1, 1, 0, "R4 debug register"); nxt();
        dbgreg_req = 0;
        expect_out(1, 1, 0, "R4 debug register tail"); nxt();
        expect_out(0, 1, 0, "R4 window closed"); nxt();
        // R5: irq through synchronizer
        irq_n = 0;
        expect_out(0, 1, 0, "R5 irq edge1"); nxt();
        expect_out(0, 1, 0, "R5 irq edge2"); nxt();
        expect_out(0, 1, 0, "R5 irq edge3"); nxt();
        irq_n = 1;
        expect_out(1, 0, 0, "R5 irq exit"); nxt();
        run_cycles(3, "R5 running");

        // R5: debug wake
        wait_req = 1; wait_kind = 0;
        expect_out(1, 0, 0, "R5 accept"); nxt();
        wait_req = 0;
        expect_out(0, 1, 0, "R3 direct entry"); nxt();
        dbg_wake = 1;
        expect_out(0, 1, 0, "R5 debug wake"); nxt();
        dbg_wake = 0;
        expect_out(1, 0, 0, "R5 debug exit"); nxt();

        // R6: event-kind wait, exit on event
        wait_req = 1; wait_kind = 1;
        expect_out(1, 0, 0, "R6 accept"); nxt();
        wait_req = 0; wait_kind = 0;
        expect_out(0, 0, 1, "R3 event standby"); nxt();
        event_in = 1;
        expect_out(0, 0, 1, "R6 event seen"); nxt();
        event_in = 0;
        expect_out(1, 0, 0, "R6 event exit"); nxt();

        // R6: event-kind wait, exit on fiq
        wait_req = 1; wait_kind = 1;
        expect_out(1, 0, 0, "R6 accept"); nxt();
        wait_req = 0; fiq_n = 0;
        expect_out(0, 0, 1, "R6 fiq edge1"); nxt();
        expect_out(0, 0, 1, "R6 fiq edge2"); nxt();
        expect_out(0, 0, 1, "R6 fiq edge3"); nxt();
        fiq_n = 1;
        expect_out(1, 0, 0, "R6 fiq exit"); nxt();
        run_cycles(3, "R6 running");

        // R8: wake in accept cycle
        wait_req = 1; wait_kind = 1; event_in = 1;
        expect_out(1, 0, 0, "R8 accept with event"); nxt();
        wait_req = 0; event_in = 0;
        expect_out(0, 0, 1, "R8 one standby cycle"); nxt();
        expect_out(1, 0, 0, "R8 exit"); nxt();

        // R8: wake during drain
        wait_req = 1; wait_kind = 0; pend_loads = 1;
        expect_out(1, 0, 0, "R8 accept"); nxt();
        wait_req = 0; dbg_wake = 1;
        expect_out(1, 0, 0, "R8 drain with wake"); nxt();
        dbg_wake = 0; pend_loads = 0;
        expect_out(1, 0, 0, "R8 drain"); nxt();
        expect_out(0, 1, 0, "R8 one standby cycle"); nxt();
        expect_out(1, 0, 0, "R8 exit"); nxt();

        // Service and wake in the same cycle (R4, R6)
        wait_req = 1; wait_kind = 1;
        expect_out(1, 0, 0, "R6 accept"); nxt();
        wait_req = 0;
        expect_out(0, 0, 1, "R3 event standby"); nxt();
        snoop_req = 1; event_in = 1;
        expect_out(1, 0, 1, "R4 snoop with event"); nxt();
        snoop_req = 0; event_in = 0;
        expect_out(1, 0, 0, "R6 exit despite snoop"); nxt();

        // R7: soft reset in sleep and in drain
        wait_req = 1; wait_kind = 0;
        expect_out(1, 0, 0, "R7 accept"); nxt();
        wait_req = 0; soft_rst = 1;
        expect_out(0, 1, 0, "R7 soft reset seen"); nxt();
        soft_rst = 0;
        expect_out(1, 0, 0, "R7 soft reset exit"); nxt();
        wait_req = 1; pend_stores = 3;
        expect_out(1, 0, 0, "R7 accept"); nxt();
        wait_req = 0; soft_rst = 1;
        expect_out(1, 0, 0, "R7 drain"); nxt();
        soft_rst = 0; pend_stores = 0;
        expect_out(1, 0, 0, "R7 abort drain"); nxt();
        expect_out(1, 0, 0, "R7 stays running"); nxt();

        // R7: async reset in sleep
        wait_req = 1; wait_kind = 1;
        expect_out(1, 0, 0, "R7 accept"); nxt();
        wait_req = 0;
        expect_out(0, 0, 1, "R7 sleeping"); nxt();
        rst_n = 0;
        expect_out(1, 0, 0, "R7 async reset"); nxt();
        rst_n = 1;
        run_cycles(2, "R10 after reset");

        nxt();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule